// File: doc/BRIEF.md
# Register Vector-Tag Classification Unit

This unit lets ordinary scalar instructions run as vector operations with no change to their opcodes. Software programs two tag words through a simple configuration port. The first word has one bit per integer register and the second has one bit per floating-point register. A set bit means that register is handled as a vector whenever an instruction names it. For each decoded instruction, the unit looks up the tag bit of every register index the instruction uses. It then reports a per-operand vector flag and a class for the whole operation: scalar-scalar, vector-scalar or vector-vector.

The unit also keeps a binding table with one entry per integer destination register. An entry can name a second register that supplies the predicate. Any later integer instruction that writes a bound destination is reported as predicated by that register. The binding looks only at the destination, so a bound register used as a source has no effect. Decode and execution sit outside the unit. It only turns register indices into flags.

Top module: `vtag_classify_unit`

## Requirements
- R1: After reset, reading either tag word returns 0, every binding entry reads 0 (not bound), and every instruction classifies as scalar-scalar and unpredicated.
- R2: Configuration address 0 holds the integer tag word, where bit k marks integer register k as a vector. Reads are combinational. A write is seen by classification only from the clock edge that stores it onward.
- R3: Configuration address 1 holds the floating-point tag word, where bit k marks floating-point register k. It is independent of the integer word.
- R4: Integer register 0 is never a vector and never bound. Bit 0 of the integer tag word always reads 0, and a write to binding entry 0 is ignored, so it reads 0.
- R5: Each source flag `src_vec[i]` and the destination flag `dst_vec` are 1 exactly when that operand is marked used and its register's tag bit is set. The bit comes from the floating-point word when `inst_is_fp` is 1, and from the integer word otherwise.
- R6: `op_class` is computed over the used operands. It is 2'b10 (vector-vector) when at least one operand is used and all used operands are vector. It is 2'b01 (vector-scalar) when some but not all used operands are vector. It is 2'b00 (scalar-scalar) when no used operand is vector.
- R7: Configuration addresses 32+d hold the binding entry for destination d. Bit 5 is the valid bit and bits 4:0 are the predicate register index. Addresses 2 to 31 read 0, and writes to them are ignored.
- R8: `pred_en` is 1 and `pred_idx` gives the bound index when `inst_dst_used` is 1, `inst_is_fp` is 0 and the entry for `inst_dst_idx` is valid. Otherwise `pred_en` is 0 and `pred_idx` is 0.
- R9: A binding has no effect through source operands. An instruction that reads a bound register, with no destination used, stays unpredicated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_addr | input | 6 | Configuration write address |
| cfg_wr_data | input | 32 | Configuration write data |
| cfg_rd_addr | input | 6 | Configuration read address |
| cfg_rd_data | output | 32 | Combinational read data |
| inst_is_fp | input | 1 | Instruction uses the floating-point register file |
| inst_src_idx | input | 10 | Source register indices, 5 bits each, source 0 in the low bits |
| inst_src_used | input | 2 | Source operand present flags |
| inst_dst_idx | input | 5 | Destination register index |
| inst_dst_used | input | 1 | Destination operand present |
| src_vec | output | 2 | Per-source vector flags |
| dst_vec | output | 1 | Destination vector flag |
| op_class | output | 2 | Operation class |
| pred_en | output | 1 | Destination is predicated |
| pred_idx | output | 5 | Predicate register index |

## Verification
Every pair of source indices is swept in both register files. The destination index and the operand-used mask are derived arithmetically from that pair, so each mask shape is reached many times. Two tag patterns are used. A sparse mixed pattern separates the integer and floating-point lookups and produces all three classes. An all-vector integer word with an empty floating-point word shows that classification ignores unused operands and that bit 0 stays scalar. Alternating valid bindings, together with an attempted binding of entry 0, separate destination-only predication from source references. A write followed by a lookup just before the storing edge shows exactly when a new tag takes effect.

// File: rtl/vtag_pkg.sv
package vtag_pkg;
   typedef enum logic [1:0] {
      OPC_SCALAR = 2'b00,
      OPC_MIXED  = 2'b01,
      OPC_VECTOR = 2'b10
   } vtag_opclass_e;

   localparam int unsigned ADDR_INT_TAGS = 0;
   localparam int unsigned ADDR_FP_TAGS  = 1;
endpackage

// File: rtl/vtag_tag_reg.sv
module vtag_tag_reg #(
   parameter int unsigned NREG     = 32,
   parameter bit          ZERO_LSB = 1'b0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_en,
   input  logic [NREG-1:0] wr_data,
   output logic [NREG-1:0] tags
);
   for (genvar b = 0; b < NREG; b++) begin : g_bit
      if (ZERO_LSB && b == 0) begin : g_tied
         assign tags[b] = 1'b0;
      end else begin : g_flop
         logic bit_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     bit_q <= 1'b0;
            else if (wr_en) bit_q <= wr_data[b];
         end
         assign tags[b] = bit_q;
      end
   end
endmodule

// File: rtl/vtag_bind_table.sv
module vtag_bind_table #(
   parameter int unsigned NREG  = 32,
   parameter int unsigned IDX_W = $clog2(NREG)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_sel,
   input  logic             wr_valid,
   input  logic [IDX_W-1:0] wr_pidx,
   input  logic [IDX_W-1:0] rd_sel,
   output logic             rd_valid,
   output logic [IDX_W-1:0] rd_pidx,
   input  logic [IDX_W-1:0] lk_sel,
   output logic             lk_valid,
   output logic [IDX_W-1:0] lk_pidx
);
   logic [NREG-1:0]  ent_valid;
   logic [IDX_W-1:0] ent_pidx [NREG];

   for (genvar e = 0; e < NREG; e++) begin : g_ent
      if (e == 0) begin : g_null
         assign ent_valid[e] = 1'b0;
         assign ent_pidx[e]  = '0;
      end else begin : g_live
         logic             v_q;
         logic [IDX_W-1:0] p_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               v_q <= 1'b0;
               p_q <= '0;
            end else if (wr_en && wr_sel == IDX_W'(e)) begin
               v_q <= wr_valid;
               p_q <= wr_pidx;
            end
         end
         assign ent_valid[e] = v_q;
         assign ent_pidx[e]  = p_q;
      end
   end

   assign rd_valid = ent_valid[rd_sel];
   assign rd_pidx  = ent_valid[rd_sel] ? ent_pidx[rd_sel] : '0;
   assign lk_valid = ent_valid[lk_sel];
   assign lk_pidx  = ent_pidx[lk_sel];
endmodule

// File: rtl/vtag_classifier.sv
module vtag_classifier #(
   parameter int unsigned NOPS = 3
) (
   input  logic [NOPS-1:0] op_vec,
   input  logic [NOPS-1:0] op_used,
   output logic [1:0]      op_class
);
   import vtag_pkg::*;
   localparam int unsigned CNT_W = $clog2(NOPS + 1);

   logic [CNT_W-1:0] n_used, n_vec;

   always_comb begin
      n_used = '0;
      n_vec  = '0;
      for (int k = 0; k < NOPS; k++) begin
         n_used = n_used + CNT_W'(op_used[k]);
         n_vec  = n_vec + CNT_W'(op_used[k] & op_vec[k]);
      end
      if (n_vec == '0)          op_class = OPC_SCALAR;
      else if (n_vec == n_used) op_class = OPC_VECTOR;
      else                      op_class = OPC_MIXED;
   end
endmodule

// File: rtl/vtag_classify_unit.sv
module vtag_classify_unit #(
   parameter int unsigned NREG   = 32,
   parameter int unsigned NSRC   = 2,
   parameter bit          HAS_FP = 1'b1,
   parameter int unsigned IDX_W  = $clog2(NREG),
   parameter int unsigned CFG_AW = IDX_W + 1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  cfg_wr_en,
   input  logic [CFG_AW-1:0]     cfg_wr_addr,
   input  logic [NREG-1:0]       cfg_wr_data,
   input  logic [CFG_AW-1:0]     cfg_rd_addr,
   output logic [NREG-1:0]       cfg_rd_data,
   input  logic                  inst_is_fp,
   input  logic [NSRC*IDX_W-1:0] inst_src_idx,
   input  logic [NSRC-1:0]       inst_src_used,
   input  logic [IDX_W-1:0]      inst_dst_idx,
   input  logic                  inst_dst_used,
   output logic [NSRC-1:0]       src_vec,
   output logic                  dst_vec,
   output logic [1:0]            op_class,
   output logic                  pred_en,
   output logic [IDX_W-1:0]      pred_idx
);
   import vtag_pkg::*;

   localparam int unsigned NOPS = NSRC + 1;

   if (NREG < 4 || (1 << IDX_W) != NREG) begin : g_bad_nreg
      $error("NREG must be a power of two of at least 4");
   end
   if (NREG < IDX_W + 1) begin : g_bad_width
      $error("NREG too small to carry a binding entry");
   end
   if (NSRC < 1) begin : g_bad_nsrc
      $error("NSRC must be at least 1");
   end

   logic wr_int, wr_fp, wr_bind;
   assign wr_int  = cfg_wr_en && cfg_wr_addr == CFG_AW'(ADDR_INT_TAGS);
   assign wr_fp   = cfg_wr_en && cfg_wr_addr == CFG_AW'(ADDR_FP_TAGS);
   assign wr_bind = cfg_wr_en && cfg_wr_addr[CFG_AW-1];

   logic [NREG-1:0] int_tags, fp_tags;

   vtag_tag_reg #(.NREG(NREG), .ZERO_LSB(1'b1)) u_int_tags (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_int),
      .wr_data(cfg_wr_data), .tags(int_tags)
   );

   if (HAS_FP) begin : g_fp
      vtag_tag_reg #(.NREG(NREG), .ZERO_LSB(1'b0)) u_fp_tags (
         .clk(clk), .rst_n(rst_n), .wr_en(wr_fp),
         .wr_data(cfg_wr_data), .tags(fp_tags)
      );
   end else begin : g_no_fp
      assign fp_tags = '0;
   end

   logic             bind_rd_valid, bind_lk_valid;
   logic [IDX_W-1:0] bind_rd_pidx, bind_lk_pidx;

   vtag_bind_table #(.NREG(NREG), .IDX_W(IDX_W)) u_bind (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_bind),
      .wr_sel(cfg_wr_addr[IDX_W-1:0]),
      .wr_valid(cfg_wr_data[IDX_W]),
      .wr_pidx(cfg_wr_data[IDX_W-1:0]),
      .rd_sel(cfg_rd_addr[IDX_W-1:0]),
      .rd_valid(bind_rd_valid),
      .rd_pidx(bind_rd_pidx),
      .lk_sel(inst_dst_idx),
      .lk_valid(bind_lk_valid),
      .lk_pidx(bind_lk_pidx)
   );

   always_comb begin
      cfg_rd_data = '0;
      if (cfg_rd_addr[CFG_AW-1]) begin
         cfg_rd_data[IDX_W]     = bind_rd_valid;
         cfg_rd_data[IDX_W-1:0] = bind_rd_pidx;
      end else if (cfg_rd_addr == CFG_AW'(ADDR_INT_TAGS)) begin
         cfg_rd_data = int_tags;
      end else if (cfg_rd_addr == CFG_AW'(ADDR_FP_TAGS)) begin
         cfg_rd_data = fp_tags;
      end
   end

   logic [NREG-1:0] sel_tags;
   assign sel_tags = inst_is_fp ? fp_tags : int_tags;

   for (genvar s = 0; s < NSRC; s++) begin : g_src
      logic [IDX_W-1:0] idx;
      assign idx        = inst_src_idx[s*IDX_W +: IDX_W];
      assign src_vec[s] = inst_src_used[s] & sel_tags[idx];
   end
   assign dst_vec = inst_dst_used & sel_tags[inst_dst_idx];

   vtag_classifier #(.NOPS(NOPS)) u_class (
      .op_vec({dst_vec, src_vec}),
      .op_used({inst_dst_used, inst_src_used}),
      .op_class(op_class)
   );

   assign pred_en  = inst_dst_used & ~inst_is_fp & bind_lk_valid;
   assign pred_idx = pred_en ? bind_lk_pidx : '0;
endmodule

// File: rtl/vtag_classify_chk.sv
module vtag_classify_chk #(
   parameter int unsigned NREG   = 32,
   parameter int unsigned NSRC   = 2,
   parameter int unsigned IDX_W  = $clog2(NREG),
   parameter int unsigned CFG_AW = IDX_W + 1
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic [CFG_AW-1:0]     cfg_rd_addr,
   input logic [NREG-1:0]       cfg_rd_data,
   input logic                  inst_is_fp,
   input logic [NSRC-1:0]       inst_src_used,
   input logic                  inst_dst_used,
   input logic [NSRC-1:0]       src_vec,
   input logic                  dst_vec,
   input logic [1:0]            op_class,
   input logic                  pred_en,
   input logic [IDX_W-1:0]      pred_idx
);
   assert_int_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_rd_addr == '0) |-> (cfg_rd_data[0] == 1'b0));

   assert_unused_flags_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ((src_vec & ~inst_src_used) == '0) && !(dst_vec && !inst_dst_used));

   assert_vector_class_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (op_class == 2'b10) |->
         ({dst_vec, src_vec} == {inst_dst_used, inst_src_used}));

   assert_scalar_class_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (op_class == 2'b00) |-> ({dst_vec, src_vec} == '0));

   assert_pred_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
      pred_en |-> (inst_dst_used && !inst_is_fp));

   assert_pred_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !pred_en |-> (pred_idx == '0));
endmodule

bind vtag_classify_unit vtag_classify_chk #(
   .NREG(NREG), .NSRC(NSRC), .IDX_W(IDX_W), .CFG_AW(CFG_AW)
) u_chk (
   .clk(clk), .rst_n(rst_n), .cfg_rd_addr(cfg_rd_addr),
   .cfg_rd_data(cfg_rd_data), .inst_is_fp(inst_is_fp),
   .inst_src_used(inst_src_used), .inst_dst_used(inst_dst_used),
   .src_vec(src_vec), .dst_vec(dst_vec), .op_class(op_class),
   .pred_en(pred_en), .pred_idx(pred_idx)
);

// File: tb/tb_vtag_classify_unit.sv
module tb_vtag_classify_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_wr_en = 1'b0;
   logic [5:0]  cfg_wr_addr = '0;
   logic [31:0] cfg_wr_data = '0;
   logic [5:0]  cfg_rd_addr = '0;
   logic [31:0] cfg_rd_data;
   logic        inst_is_fp = 1'b0;
   logic [9:0]  inst_src_idx = '0;
   logic [1:0]  inst_src_used = '0;
   logic [4:0]  inst_dst_idx = '0;
   logic        inst_dst_used = 1'b0;
   logic [1:0]  src_vec;
   logic        dst_vec;
   logic [1:0]  op_class;
   logic        pred_en;
   logic [4:0]  pred_idx;

   int checks = 0;
   int errors = 0;

   logic [31:0] m_int = '0, m_fp = '0;
   logic        m_bv [32];
   logic [4:0]  m_bp [32];

   always #4 clk = ~clk;

   vtag_classify_unit dut (
      .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en),
      .cfg_wr_addr(cfg_wr_addr), .cfg_wr_data(cfg_wr_data),
      .cfg_rd_addr(cfg_rd_addr), .cfg_rd_data(cfg_rd_data),
      .inst_is_fp(inst_is_fp), .inst_src_idx(inst_src_idx),
      .inst_src_used(inst_src_used), .inst_dst_idx(inst_dst_idx),
      .inst_dst_used(inst_dst_used), .src_vec(src_vec), .dst_vec(dst_vec),
      .op_class(op_class), .pred_en(pred_en), .pred_idx(pred_idx)
   );

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic cfg_write(input logic [5:0] a, input logic [31:0] d);
      @(negedge clk);
      cfg_wr_en = 1'b1; cfg_wr_addr = a; cfg_wr_data = d;
      @(posedge clk); #1;
      cfg_wr_en = 1'b0;
   endtask

   function automatic logic [31:0] exp_read(input int a);
      if (a == 0) return m_int;
      if (a == 1) return m_fp;
      if (a >= 32) return m_bv[a-32] ? {26'd0, 1'b1, m_bp[a-32]} : 32'd0;
      return 32'd0;
   endfunction

   task automatic read_all(input string req);
      for (int a = 0; a < 64; a++) begin
         cfg_rd_addr = 6'(a); #1;
         chk(cfg_rd_data == exp_read(a), req, cfg_rd_data, exp_read(a));
      end
   endtask

   task automatic sweep(input string tag);
      for (int fp = 0; fp < 2; fp++)
         for (int a = 0; a < 32; a++)
            for (int b = 0; b < 32; b++) begin
               logic [2:0] u;
               logic [4:0] d;
               logic [31:0] t;
               logic [2:0] ev;
               logic [1:0] ec;
               logic ep;
               logic [4:0] ei;
               u = 3'((a + b + fp) % 8);
               d = 5'((a * 3 + b) % 32);
               t = fp ? m_fp : m_int;
               ev = {u[2] & t[d], u[1] & t[b], u[0] & t[a]};
               if (ev == 3'b000) ec = 2'b00;
               else if (ev == u) ec = 2'b10;
               else ec = 2'b01;
               ep = u[2] && fp == 0 && m_bv[d];
               ei = ep ? m_bp[d] : 5'd0;
               inst_is_fp = 1'(fp); inst_src_idx = {5'(b), 5'(a)};
               inst_src_used = u[1:0]; inst_dst_used = u[2]; inst_dst_idx = d;
               #1;
               chk({dst_vec, src_vec} == ev, {"R5 flags ", tag}, {dst_vec, src_vec}, ev);
               chk(op_class == ec, {"R6 class ", tag}, op_class, ec);
               chk(pred_en == ep && pred_idx == ei, {"R8 predicate ", tag},
                   {pred_en, pred_idx}, {ep, ei});
            end
   endtask

   initial begin
      #(8 * 200000);
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      for (int i = 0; i < 32; i++) begin m_bv[i] = 1'b0; m_bp[i] = '0; end
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);

      // R1: reset contents and scalar behaviour
      read_all("R1 reset read");
      inst_src_idx = {5'd7, 5'd3}; inst_src_used = 2'b11;
      inst_dst_idx = 5'd9; inst_dst_used = 1'b1; #1;
      chk(op_class == 2'b00 && !pred_en, "R1 reset class", {op_class, pred_en}, 0);

      // R2: timing of a tag write; R4 bit 0 forced low
      @(negedge clk);
      inst_is_fp = 1'b0; inst_src_idx = {5'd0, 5'd3}; inst_src_used = 2'b01;
      inst_dst_used = 1'b0;
      cfg_wr_en = 1'b1; cfg_wr_addr = 6'd0; cfg_wr_data = 32'hFFFF_FFFF;
      #2;
      chk(src_vec == 2'b00, "R2 before edge", src_vec, 0);
      @(posedge clk); #1;
      cfg_wr_en = 1'b0;
      chk(src_vec == 2'b01, "R2 after edge", src_vec, 1);
      m_int = 32'hFFFF_FFFE;
      cfg_rd_addr = 6'd0; #1;
      chk(cfg_rd_data == 32'hFFFF_FFFE, "R4 integer bit zero", cfg_rd_data, 32'hFFFF_FFFE);
      inst_src_idx = {5'd0, 5'd0}; inst_src_used = 2'b11; #1;
      chk(src_vec == 2'b00, "R4 register zero scalar", src_vec, 0);

      // R3: floating-point word independent
      cfg_write(6'd1, 32'hA5A5_A5A5); m_fp = 32'hA5A5_A5A5;
      cfg_rd_addr = 6'd1; #1;
      chk(cfg_rd_data == 32'hA5A5_A5A5, "R3 fp read", cfg_rd_data, 32'hA5A5_A5A5);
      cfg_rd_addr = 6'd0; #1;
      chk(cfg_rd_data == m_int, "R3 integer untouched", cfg_rd_data, m_int);

      // R7: unmapped writes ignored; bindings
      cfg_write(6'd5, 32'hFFFF_FFFF);
      cfg_write(6'd32, 32'h0000_0027);  // R4: entry 0 ignored
      for (int d = 1; d < 32; d++) begin
         cfg_write(6'(32 + d), {26'd0, 1'(d % 2), 5'((d * 7) % 32)});
         m_bv[d] = 1'(d % 2);
         m_bp[d] = 5'((d * 7) % 32);
      end
      read_all("R7 map read");

      // R9: bound register as source only
      inst_is_fp = 1'b0; inst_src_idx = {5'd3, 5'd1}; inst_src_used = 2'b11;
      inst_dst_used = 1'b0; inst_dst_idx = 5'd1; #1;
      chk(!pred_en && pred_idx == 0, "R9 source not predicated", {pred_en, pred_idx}, 0);
      inst_dst_used = 1'b1; #1;
      chk(pred_en && pred_idx == 5'd7, "R8 destination predicated", {pred_en, pred_idx}, 6'h27);

      // R5 R6 R8 sweeps under two tag patterns
      cfg_write(6'd0, 32'h0F0F_3C3D); m_int = 32'h0F0F_3C3C;
      sweep("mixed");
      cfg_write(6'd0, 32'hFFFF_FFFF); m_int = 32'hFFFF_FFFE;
      cfg_write(6'd1, 32'h0000_0000); m_fp = 32'h0;
      sweep("full");

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule